// File: doc/BRIEF.md
# Integer ALU with NZCV and sticky saturation flags

This block is the integer arithmetic and logic unit of a small processor datapath. Each cycle it takes two operands, a 4-bit operation code, a set-flags enable and the carry produced by the upstream shifter. The second operand arrives already shifted. The block returns the result and a write-enable for the destination register in the same cycle. A flag register holding negative, zero, carry and overflow, plus a sticky saturation flag, is updated at the next rising clock edge.

The carry used by add-with-carry and subtract-with-carry is the carry bit of the block's own flag register. Subtraction treats the carry as an active-high "no borrow". Compare and test operations change only the flags. The saturating operations clamp signed overflow and leave a sticky mark that only an explicit clear input removes. Multiply, divide, shifting and instruction decode are handled elsewhere.

Top module: `alu_nzcv`

## Requirements
- R1: While `rst_n` is low, and after any reset, `flag_n`, `flag_z`, `flag_c`, `flag_v` and `flag_q` read 0.
- R2: For codes 0 (add), 1 (add with carry: A+B+C) and 13 (compare-negative, A+B), `result` is the sum truncated to WIDTH bits. C is the carry out of the top bit. V is set when both addends have the same sign and the sum's sign differs from it.
- R3: For codes 2 (subtract, A−B), 3 (subtract with carry: A−B+C−1), 4 (reverse subtract, B−A) and 12 (compare, A−B), C is 1 exactly when no borrow occurs. V is set when the operands' signs differ and the result's sign differs from the minuend's.
- R4: The logic codes give: 7 A AND B, 8 A AND NOT B, 9 A OR B, 10 A OR NOT B, 11 A XOR B, 14 A AND B (test), 15 A XOR B (test-equivalence).
- R5: When a logic or test code updates the flags, N is the top result bit and Z marks an all-zero result. C takes `shift_carry` and V keeps its previous value.
- R6: For codes 0 to 4 and 7 to 11 with `set_flags` low, N, Z, C and V keep their values.
- R7: Codes 12 to 15 update N, Z, C and V whatever `set_flags` says, and drive `write_en` low. Every other code drives `write_en` high.
- R8: Codes 5 (saturating A+B) and 6 (saturating A−B) replace a signed overflow by the largest positive value (0x7FFFFFFF) or the most negative value (0x80000000), following the true sign, and then set Q. They never change N, Z, C or V. No other code sets Q.
- R9: Q stays set until `q_clear` is sampled high. A saturation in the same cycle as `q_clear` leaves Q set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter, used by logic and test codes |
| set_flags | input | 1 | Update N, Z, C and V for non-compare codes |
| q_clear | input | 1 | Clears the sticky saturation flag |
| result | output | WIDTH | Combinational result |
| write_en | output | 1 | High when the result should be written to a register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, also the carry-in of codes 1 and 3 |
| flag_v | output | 1 | Overflow flag |
| flag_q | output | 1 | Sticky saturation flag |

## Verification
`result` and `write_en` are combinational. They are due in the same cycle as the operands and code, so the bench drives on the falling edge and samples them one nanosecond later, before the next rising edge. The five flags only move at the rising edge that captures that operation, so the bench samples them one nanosecond after that edge. Each operation is held for exactly one edge. The carry-dependent codes therefore see the carry left by the vector before them, and the expected table is ordered with that in mind.

// File: rtl/alu_nzcv_pkg.sv
`timescale 1ns/1ps
package alu_nzcv_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_RSB  = 4'd4,
      OP_QADD = 4'd5,
      OP_QSUB = 4'd6,
      OP_AND  = 4'd7,
      OP_BIC  = 4'd8,
      OP_ORR  = 4'd9,
      OP_ORN  = 4'd10,
      OP_EOR  = 4'd11,
      OP_CMP  = 4'd12,
      OP_CMN  = 4'd13,
      OP_TST  = 4'd14,
      OP_TEQ  = 4'd15
   } alu_op_e;

   function automatic logic op_is_test(input alu_op_e op);
      return (op == OP_CMP) || (op == OP_CMN) || (op == OP_TST) || (op == OP_TEQ);
   endfunction

   function automatic logic op_is_sat(input alu_op_e op);
      return (op == OP_QADD) || (op == OP_QSUB);
   endfunction

   function automatic logic op_is_arith(input alu_op_e op);
      return (op <= OP_QSUB) || (op == OP_CMP) || (op == OP_CMN);
   endfunction

endpackage

// File: rtl/alu_nzcv_adder.sv
`timescale 1ns/1ps
module alu_nzcv_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_nzcv_adder: WIDTH must be at least 2");
      end

      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = c_in;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x_in[i] ^ y_in[i] ^ chain[i];
            assign chain[i+1] = (x_in[i] & y_in[i]) | (chain[i] & (x_in[i] ^ y_in[i]));
         end
         assign c_out = chain[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide  = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};
         assign sum   = wide[MSB:0];
         assign c_out = wide[WIDTH];
      end
   endgenerate

   assign ovf = (x_in[MSB] == y_in[MSB]) && (sum[MSB] != x_in[MSB]);

endmodule

// File: rtl/alu_nzcv_logic.sv
`timescale 1ns/1ps
module alu_nzcv_logic
   import alu_nzcv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a_in & b_in;
         OP_BIC:         res = a_in & ~b_in;
         OP_ORR:         res = a_in | b_in;
         OP_ORN:         res = a_in | ~b_in;
         OP_EOR, OP_TEQ: res = a_in ^ b_in;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/alu_nzcv_flags.sv
`timescale 1ns/1ps
module alu_nzcv_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_nzcv,
   input  logic n_nxt,
   input  logic z_nxt,
   input  logic c_nxt,
   input  logic v_nxt,
   input  logic sat_hit,
   input  logic q_clr,
   output logic n_q,
   output logic z_q,
   output logic c_q,
   output logic v_q,
   output logic q_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= 1'b0;
         z_q <= 1'b0;
         c_q <= 1'b0;
         v_q <= 1'b0;
      end else if (upd_nzcv) begin
         n_q <= n_nxt;
         z_q <= z_nxt;
         c_q <= c_nxt;
         v_q <= v_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_q <= 1'b0;
      else if (sat_hit) q_q <= 1'b1;
      else if (q_clr)   q_q <= 1'b0;
   end

endmodule

// File: rtl/alu_nzcv.sv
`timescale 1ns/1ps
module alu_nzcv
   import alu_nzcv_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             shift_carry,
   input  logic             set_flags,
   input  logic             q_clear,
   output logic [WIDTH-1:0] result,
   output logic             write_en,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v,
   output logic             flag_q
);

   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] SAT_POS = {1'b0, {MSB{1'b1}}};
   localparam logic [WIDTH-1:0] SAT_NEG = {1'b1, {MSB{1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_nzcv: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] add_x, add_y, add_sum, log_res;
   logic             add_cin, add_cout, add_ovf;
   logic             is_test, is_sat, is_arith;
   logic             c_nxt, v_nxt, upd_nzcv;

   assign op       = alu_op_e'(op_sel);
   assign is_test  = op_is_test(op);
   assign is_sat   = op_is_sat(op);
   assign is_arith = op_is_arith(op);

   // operand routing: subtraction is x + ~y + carry
   always_comb begin
      add_x   = opnd_a;
      add_y   = opnd_b;
      add_cin = 1'b0;
      unique case (op)
         OP_ADC:                 add_cin = flag_c;
         OP_SUB, OP_CMP, OP_QSUB: begin
            add_y   = ~opnd_b;
            add_cin = 1'b1;
         end
         OP_SBC: begin
            add_y   = ~opnd_b;
            add_cin = flag_c;
         end
         OP_RSB: begin
            add_x   = opnd_b;
            add_y   = ~opnd_a;
            add_cin = 1'b1;
         end
         default: ;
      endcase
   end

   alu_nzcv_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x_in  (add_x),
      .y_in  (add_y),
      .c_in  (add_cin),
      .sum   (add_sum),
      .c_out (add_cout),
      .ovf   (add_ovf)
   );

   alu_nzcv_logic #(.WIDTH(WIDTH)) u_log (
      .op   (op),
      .a_in (opnd_a),
      .b_in (opnd_b),
      .res  (log_res)
   );

   always_comb begin
      if (is_sat && add_ovf)
         result = add_x[MSB] ? SAT_NEG : SAT_POS;
      else if (is_arith)
         result = add_sum;
      else
         result = log_res;
   end

   assign write_en = !is_test;
   assign c_nxt    = is_arith ? add_cout : shift_carry;
   assign v_nxt    = is_arith ? add_ovf  : flag_v;
   assign upd_nzcv = is_test || (set_flags && !is_sat);

   alu_nzcv_flags u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_nzcv (upd_nzcv),
      .n_nxt    (result[MSB]),
      .z_nxt    (result == '0),
      .c_nxt    (c_nxt),
      .v_nxt    (v_nxt),
      .sat_hit  (is_sat && add_ovf),
      .q_clr    (q_clear),
      .n_q      (flag_n),
      .z_q      (flag_z),
      .c_q      (flag_c),
      .v_q      (flag_v),
      .q_q      (flag_q)
   );

endmodule

// File: rtl/alu_nzcv_chk.sv
`timescale 1ns/1ps
module alu_nzcv_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             shift_carry,
   input logic             set_flags,
   input logic             q_clear,
   input logic [WIDTH-1:0] result,
   input logic             write_en,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c,
   input logic             flag_v,
   input logic             flag_q
);

   logic           k_test, k_sat, k_logic;
   logic [WIDTH:0] ref_sum;
   logic [3:0]     nzcv;

   assign k_test  = op_sel >= 4'd12;
   assign k_sat   = (op_sel == 4'd5) || (op_sel == 4'd6);
   assign k_logic = (op_sel >= 4'd7) && (op_sel <= 4'd11);
   assign ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
   assign nzcv    = {flag_n, flag_z, flag_c, flag_v};

   assert_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'd0 && set_flags) |=> flag_c == $past(ref_sum[WIDTH]));

   assert_logic_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (k_logic && set_flags) |=> (flag_c == $past(shift_carry)) && $stable(flag_v));

   assert_hold_nzcv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_flags && !k_test && !k_sat) |=> $stable(nzcv));

   assert_cmp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      k_test |=> flag_z == ($past(result) == '0));

   assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !k_test |-> write_en);

   assert_sat_nzcv_R8: assert property (@(posedge clk) disable iff (!rst_n)
      k_sat |=> $stable(nzcv));

   assert_q_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(k_sat));

   assert_q_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !q_clear) |=> flag_q);

   assert_q_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_clear && !k_sat) |=> !flag_q);

endmodule

bind alu_nzcv alu_nzcv_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_sel      (op_sel),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .shift_carry (shift_carry),
   .set_flags   (set_flags),
   .q_clear     (q_clear),
   .result      (result),
   .write_en    (write_en),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .flag_c      (flag_c),
   .flag_v      (flag_v),
   .flag_q      (flag_q)
);

// File: tb/sim_alu_nzcv.sv
`timescale 1ns/1ps
module sim_alu_nzcv;
   import alu_nzcv_pkg::*;

   typedef struct packed {
      logic [15:0] tag;
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic        sf;
      logic        shc;
      logic [31:0] res;
      logic        we;
      logic [3:0]  nzcv;
      logic        q;
   } vec_t;

   localparam int NV = 26;
   // expected flags are {N,Z,C,V}; order matters since codes 1 and 3 read C
   localparam vec_t TBL [NV] = '{
      '{"R2", OP_ADD,  32'h00000001, 32'h00000002, 1'b1, 1'b0, 32'h00000003, 1'b1, 4'b0000, 1'b0},
      '{"R2", OP_ADD,  32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b0, 32'h00000000, 1'b1, 4'b0110, 1'b0},
      '{"R2", OP_ADC,  32'h00000005, 32'h00000006, 1'b1, 1'b0, 32'h0000000C, 1'b1, 4'b0000, 1'b0},
      '{"R2", OP_ADD,  32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0, 32'h80000000, 1'b1, 4'b1001, 1'b0},
      '{"R3", OP_SUB,  32'h00000005, 32'h00000003, 1'b1, 1'b0, 32'h00000002, 1'b1, 4'b0010, 1'b0},
      '{"R3", OP_SBC,  32'h00000005, 32'h00000003, 1'b1, 1'b0, 32'h00000002, 1'b1, 4'b0010, 1'b0},
      '{"R3", OP_SUB,  32'h00000003, 32'h00000005, 1'b1, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000, 1'b0},
      '{"R3", OP_SBC,  32'h0000000A, 32'h00000003, 1'b1, 1'b0, 32'h00000006, 1'b1, 4'b0010, 1'b0},
      '{"R3", OP_SUB,  32'h80000000, 32'h00000001, 1'b1, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011, 1'b0},
      '{"R3", OP_RSB,  32'h00000003, 32'h0000000A, 1'b1, 1'b0, 32'h00000007, 1'b1, 4'b0010, 1'b0},
      '{"R3", OP_RSB,  32'h0000000A, 32'h00000003, 1'b1, 1'b0, 32'hFFFFFFF9, 1'b1, 4'b1000, 1'b0},
      '{"R6", OP_ADD,  32'h00000001, 32'h00000001, 1'b0, 1'b0, 32'h00000002, 1'b1, 4'b1000, 1'b0},
      '{"R4", OP_AND,  32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 1'b1, 32'hF000F000, 1'b1, 4'b1010, 1'b0},
      '{"R3", OP_SUB,  32'h80000000, 32'h00000001, 1'b1, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011, 1'b0},
      '{"R5", OP_BIC,  32'hFFFF0000, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b1, 4'b0101, 1'b0},
      '{"R4", OP_ORR,  32'h0000000F, 32'h000000F0, 1'b1, 1'b1, 32'h000000FF, 1'b1, 4'b0011, 1'b0},
      '{"R4", OP_ORN,  32'h00000000, 32'h7FFFFFFF, 1'b1, 1'b0, 32'h80000000, 1'b1, 4'b1001, 1'b0},
      '{"R5", OP_EOR,  32'hAAAAAAAA, 32'hAAAAAAAA, 1'b1, 1'b1, 32'h00000000, 1'b1, 4'b0111, 1'b0},
      '{"R7", OP_CMP,  32'h00000007, 32'h00000007, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'b0110, 1'b0},
      '{"R7", OP_CMN,  32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 32'hFFFFFFFE, 1'b0, 4'b1001, 1'b0},
      '{"R7", OP_TST,  32'h0000000F, 32'h000000F0, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0111, 1'b0},
      '{"R7", OP_TEQ,  32'h80000001, 32'h00000001, 1'b0, 1'b0, 32'h80000000, 1'b0, 4'b1001, 1'b0},
      '{"R7", OP_CMP,  32'h00000002, 32'h00000005, 1'b0, 1'b0, 32'hFFFFFFFD, 1'b0, 4'b1000, 1'b0},
      '{"R8", OP_QADD, 32'h7FFFFFF0, 32'h00000100, 1'b1, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b1000, 1'b1},
      '{"R8", OP_QSUB, 32'h80000000, 32'h00000001, 1'b1, 1'b0, 32'h80000000, 1'b1, 4'b1000, 1'b1},
      '{"R9", OP_QADD, 32'h00000002, 32'h00000003, 1'b1, 1'b0, 32'h00000005, 1'b1, 4'b1000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        shift_carry = 1'b0, set_flags = 1'b0, q_clear = 1'b0;
   logic [31:0] result;
   logic        write_en, flag_n, flag_z, flag_c, flag_v, flag_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   alu_nzcv u0 (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_carry(shift_carry), .set_flags(set_flags), .q_clear(q_clear),
      .result(result), .write_en(write_en), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v), .flag_q(flag_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // drive one operation for one edge; check comb outputs, then flags
   task automatic step(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic sf, input logic shc, input logic qc,
                       input logic [31:0] e_res, input logic e_we,
                       input logic [3:0] e_nzcv, input logic e_q);
      @(negedge clk);
      op_sel = op; opnd_a = a; opnd_b = b;
      set_flags = sf; shift_carry = shc; q_clear = qc;
      #1;
      chk({tag, " result"}, result, e_res);
      chk({tag, " write_en"}, {31'd0, write_en}, {31'd0, e_we});
      @(posedge clk);
      #1;
      chk({tag, " nzcv"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, e_nzcv});
      chk({tag, " q"}, {31'd0, flag_q}, {31'd0, e_q});
   endtask

   initial begin
      // R1: flags cleared while reset is held
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset nzcvq", {27'd0, flag_n, flag_z, flag_c, flag_v, flag_q}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(string'(TBL[i].tag), TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].sf, TBL[i].shc,
              1'b0, TBL[i].res, TBL[i].we, TBL[i].nzcv, TBL[i].q);
      end

      // R9: clear sticky Q; R6: set_flags low keeps NZCV at 1000
      step("R9 clear", OP_ADD, 32'd4, 32'd4, 1'b0, 1'b0, 1'b1, 32'd8, 1'b1, 4'b1000, 1'b0);
      // R8: positive overflow on subtract saturates high
      step("R8 qsub pos", OP_QSUB, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0,
           32'h7FFFFFFF, 1'b1, 4'b1000, 1'b1);
      // R9: saturation and clear in the same cycle keep Q set
      step("R9 set wins", OP_QADD, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b1,
           32'h7FFFFFFF, 1'b1, 4'b1000, 1'b1);
      step("R9 clear again", OP_ORR, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b1, 4'b1000, 1'b0);
      // R8: in-range saturating subtract does not set Q
      step("R8 qsub plain", OP_QSUB, 32'd10, 32'd4, 1'b1, 1'b0, 1'b0, 32'd6, 1'b1, 4'b1000, 1'b0);
      // R2: add with carry when C is 1 wraps through zero
      step("R2 set c", OP_ADD, 32'hFFFFFFFF, 32'h00000002, 1'b1, 1'b0, 1'b0, 32'd1, 1'b1, 4'b0010, 1'b0);
      step("R2 adc wrap", OP_ADC, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0, 32'd0, 1'b1, 4'b0110, 1'b0);

      // R1: reset in mid run clears every flag including Q
      step("R8 q for reset", OP_QADD, 32'h40000000, 32'h40000000, 1'b0, 1'b0, 1'b0,
           32'h7FFFFFFF, 1'b1, 4'b0110, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 mid reset", {27'd0, flag_n, flag_z, flag_c, flag_v, flag_q}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule